// File: doc/BRIEF.md
# Push-Button Sequence Lock

This block is a clocked Moore machine that opens a lock when an operator presses three push buttons in one fixed order. The buttons are named restart, zero and one. The opening order is restart, zero, one, one, zero. Each raw button line first passes through a multi-flop synchronizer. A rising-edge detector follows, so a press counts as a single event however long the button is held. The events then drive a six-state machine held in a 3-bit register. The single output is high exactly while the machine sits in its open state.

A mistake at any point sends the machine to a fault state. Further digit presses cannot leave that state. Restart is the only way out, and restart returns the machine to its idle state from anywhere, even when a digit is pressed in the same cycle. The next-state logic can be built in one of two forms, chosen by a parameter: a hand-written decode, or a 64-entry by 4-bit lookup table. The table is computed at elaboration and addressed by the state bits and the three event bits.

Top module: `seq_lock_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) places the machine in idle (code 000), and `unlock_o` is 0 from that edge on.
- R2: Each rising transition of a button makes exactly one event, however long the button stays high. A button first sampled high at clock edge k changes the state at edge k+2 (two synchronizer flops, then the state register).
- R3: From idle, the events zero, one, one, zero step through the codes 001, 010 and 011 to the open state (code 100), and `unlock_o` rises with the last step.
- R4: In idle or in either of the two middle digit states, a wrong digit sends the machine to fault (code 101). In the state that waits for the final digit, a wrong digit does the same.
- R5: A restart event moves every state to idle on the next edge, even when zero or one events occur in the same cycle.
- R6: Fault is a trap: zero and one events, alone or together, keep the machine in fault.
- R7: `unlock_o` is 1 only in the open state. A zero or one event in the open state moves the machine to fault.
- R8: In a cycle with no event, the state does not change.
- R9: Zero and one events in the same cycle, with no restart event, send the machine to fault.
- R10: The table form (`USE_TABLE`=1) and the decode form (`USE_TABLE`=0) give identical output sequences for every input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| btn_start_i | input | 1 | Raw restart button, active high, asynchronous to clk |
| btn_zero_i | input | 1 | Raw zero button, active high, asynchronous to clk |
| btn_one_i | input | 1 | Raw one button, active high, asynchronous to clk |
| unlock_o | output | 1 | High while the machine is in the open state |

## Verification
The bench goes after the cases where the machine must leave a state, or refuse to leave one. If the machine did not trap, it would return from fault to a digit state, and a later correct tail would open the lock. If zero and one pressed together were taken as a single digit, the same tail would also open it. If a held button were not reduced to one event, a long press would repeat the digit and drive the machine to fault. A restart that did not beat a digit pressed in the same cycle would leave the lock unable to open on the following correct sequence. Every step runs through both the decode form and the table form, so any entry where the two disagree shows up as a difference between them.

// File: rtl/lock_pkg.sv
package lock_pkg;

   localparam int STATE_W     = 3;
   localparam int BTN_W       = 3;
   localparam int ADDR_W      = STATE_W + BTN_W;
   localparam int TABLE_DEPTH = 1 << ADDR_W;
   localparam int ENTRY_W     = STATE_W + 1;

   // Event bit positions inside the event vector
   localparam int EV_RESTART = 2;
   localparam int EV_ZERO    = 1;
   localparam int EV_ONE     = 0;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 3'b000,
      ST_GOT1  = 3'b001,
      ST_GOT2  = 3'b010,
      ST_GOT3  = 3'b011,
      ST_OPEN  = 3'b100,
      ST_FAULT = 3'b101
   } lock_state_e;

   typedef logic [ENTRY_W-1:0] lock_entry_t;
   typedef lock_entry_t lock_table_t [TABLE_DEPTH];

   // Transition rule used to fill the lookup table: {next state, open flag}
   function automatic lock_entry_t lock_rule(input logic [STATE_W-1:0] cur,
                                             input logic [BTN_W-1:0]   ev);
      logic [STATE_W-1:0] nxt;
      logic               open_f;
      logic               valid;
      open_f = (cur == ST_OPEN);
      valid  = (cur <= ST_FAULT);
      if (ev[EV_RESTART])
         nxt = ST_IDLE;
      else if (!valid)
         nxt = ST_FAULT;
      else if (ev[EV_ZERO] && ev[EV_ONE])
         nxt = ST_FAULT;
      else if (!ev[EV_ZERO] && !ev[EV_ONE])
         nxt = cur;
      else begin
         case (cur)
            ST_IDLE: nxt = ev[EV_ZERO] ? ST_GOT1 : ST_FAULT;
            ST_GOT1: nxt = ev[EV_ONE]  ? ST_GOT2 : ST_FAULT;
            ST_GOT2: nxt = ev[EV_ONE]  ? ST_GOT3 : ST_FAULT;
            ST_GOT3: nxt = ev[EV_ZERO] ? ST_OPEN : ST_FAULT;
            default: nxt = ST_FAULT;
         endcase
      end
      return {nxt, open_f};
   endfunction

   function automatic lock_table_t build_lock_table();
      lock_table_t t;
      for (int a = 0; a < TABLE_DEPTH; a++) begin
         logic [ADDR_W-1:0] idx;
         idx  = ADDR_W'(a);
         t[a] = lock_rule(idx[ADDR_W-1:BTN_W], idx[BTN_W-1:0]);
      end
      return t;
   endfunction

endpackage

// File: rtl/lock_btn_event.sv
module lock_btn_event #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_raw,
   output logic btn_event
);

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], btn_raw};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign btn_event = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lock_next_comb.sv
module lock_next_comb
   import lock_pkg::*;
(
   input  lock_state_e      cur,
   input  logic [BTN_W-1:0] ev,
   output lock_state_e      nxt,
   output logic             open_f
);

   logic go_idle;
   logic both;
   logic z_only;
   logic o_only;
   logic any_digit;

   assign go_idle   = ev[EV_RESTART];
   assign both      = ev[EV_ZERO] & ev[EV_ONE];
   assign z_only    = ev[EV_ZERO] & ~ev[EV_ONE];
   assign o_only    = ev[EV_ONE] & ~ev[EV_ZERO];
   assign any_digit = ev[EV_ZERO] | ev[EV_ONE];

   always_comb begin
      open_f = 1'b0;
      case (cur)
         ST_IDLE:  nxt = z_only ? ST_GOT1 : (any_digit ? ST_FAULT : ST_IDLE);
         ST_GOT1:  nxt = o_only ? ST_GOT2 : (any_digit ? ST_FAULT : ST_GOT1);
         ST_GOT2:  nxt = o_only ? ST_GOT3 : (any_digit ? ST_FAULT : ST_GOT2);
         ST_GOT3:  nxt = z_only ? ST_OPEN : (any_digit ? ST_FAULT : ST_GOT3);
         ST_OPEN: begin
            open_f = 1'b1;
            nxt    = any_digit ? ST_FAULT : ST_OPEN;
         end
         ST_FAULT: nxt = ST_FAULT;
         default:  nxt = ST_FAULT;
      endcase
      if (both && (cur != ST_FAULT))
         nxt = ST_FAULT;
      if (go_idle)
         nxt = ST_IDLE;
   end

endmodule

// File: rtl/lock_next_table.sv
module lock_next_table
   import lock_pkg::*;
(
   input  lock_state_e      cur,
   input  logic [BTN_W-1:0] ev,
   output lock_state_e      nxt,
   output logic             open_f
);

   localparam lock_table_t TABLE = build_lock_table();

   logic [ADDR_W-1:0] addr;
   lock_entry_t       entry;

   assign addr   = {cur, ev};
   assign entry  = TABLE[addr];
   assign nxt    = lock_state_e'(entry[ENTRY_W-1:1]);
   assign open_f = entry[0];

endmodule

// File: rtl/seq_lock_top.sv
module seq_lock_top
   import lock_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int USE_TABLE   = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_start_i,
   input  logic btn_zero_i,
   input  logic btn_one_i,
   output logic unlock_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("seq_lock_top: SYNC_STAGES must be at least 2");
   end
   if ((USE_TABLE != 0) && (USE_TABLE != 1)) begin : g_bad_variant
      $error("seq_lock_top: USE_TABLE must be 0 or 1");
   end

   logic [BTN_W-1:0] btn_raw;
   logic [BTN_W-1:0] ev;
   lock_state_e      state_q;
   lock_state_e      state_d;
   logic             open_f;

   assign btn_raw[EV_RESTART] = btn_start_i;
   assign btn_raw[EV_ZERO]    = btn_zero_i;
   assign btn_raw[EV_ONE]     = btn_one_i;

   for (genvar g = 0; g < BTN_W; g++) begin : g_btn
      lock_btn_event #(.STAGES(SYNC_STAGES)) i_event (
         .clk       (clk),
         .rst       (rst),
         .btn_raw   (btn_raw[g]),
         .btn_event (ev[g])
      );
   end

   if (USE_TABLE == 1) begin : g_table
      lock_next_table i_next (
         .cur    (state_q),
         .ev     (ev),
         .nxt    (state_d),
         .open_f (open_f)
      );
   end else begin : g_comb
      lock_next_comb i_next (
         .cur    (state_q),
         .ev     (ev),
         .nxt    (state_d),
         .open_f (open_f)
      );
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   assign unlock_o = open_f;

endmodule

// File: rtl/lock_checker.sv
module lock_checker
   import lock_pkg::*;
(
   input logic             clk,
   input logic             rst,
   input logic [STATE_W-1:0] state,
   input logic [BTN_W-1:0] ev,
   input logic             unlock
);

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (state == ST_IDLE && !unlock));

   assert_single_event_R2: assert property (@(posedge clk) disable iff (rst)
      (ev & $past(ev)) == 3'b000);

   assert_open_entry_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(unlock) |-> ($past(state) == ST_GOT3 && $past(ev) == 3'b010));

   assert_restart_wins_R5: assert property (@(posedge clk) disable iff (rst)
      ev[EV_RESTART] |=> state == ST_IDLE);

   assert_fault_trap_R6: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FAULT && !ev[EV_RESTART]) |=> state == ST_FAULT);

   assert_open_exit_R7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_OPEN && !ev[EV_RESTART] && (ev[EV_ZERO] || ev[EV_ONE]))
      |=> state == ST_FAULT);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (ev == 3'b000 && state <= ST_FAULT) |=> $stable(state));

   assert_dual_digit_R9: assert property (@(posedge clk) disable iff (rst)
      (!ev[EV_RESTART] && ev[EV_ZERO] && ev[EV_ONE]) |=> state == ST_FAULT);

   // Unused codes 110 and 111 fall into fault unless restart is pressed (R4 family)
   assert_unused_code_R4: assert property (@(posedge clk) disable iff (rst)
      (state > ST_FAULT && !ev[EV_RESTART]) |=> state == ST_FAULT);

endmodule

bind seq_lock_top lock_checker i_lock_checker (
   .clk    (clk),
   .rst    (rst),
   .state  (state_q),
   .ev     (ev),
   .unlock (unlock_o)
);

// File: tb/test_seq_lock_top.sv
`timescale 1ns/1ps
module test_seq_lock_top;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic b_start = 1'b0;
   logic b_zero  = 1'b0;
   logic b_one   = 1'b0;
   logic unlock_c;
   logic unlock_t;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   localparam int WATCHDOG = 100000;

   always #10 clk = ~clk;   // 50 MHz

   seq_lock_top #(.USE_TABLE(0)) i_seq_lock_top (
      .clk (clk), .rst (rst), .btn_start_i (b_start),
      .btn_zero_i (b_zero), .btn_one_i (b_one), .unlock_o (unlock_c));

   seq_lock_top #(.USE_TABLE(1)) i_seq_lock_top_tbl (
      .clk (clk), .rst (rst), .btn_start_i (b_start),
      .btn_zero_i (b_zero), .btn_one_i (b_one), .unlock_o (unlock_t));

   // Entry = {restart, zero, one, expected unlock after the press}
   localparam int NV = 54;
   localparam logic [3:0] VEC [NV] = '{
      4'b0100, 4'b0010, 4'b0010, 4'b0101,   // R3 correct path opens
      4'b0010,                              // R7 digit in open -> fault
      4'b0100, 4'b0010, 4'b0110,            // R6 trap, R9 both in fault
      4'b1000, 4'b0010, 4'b0100,            // R5 restart; R4 wrong digit in idle
      4'b1000, 4'b0100, 4'b0100, 4'b0010, 4'b0010, 4'b0100,  // R4 wrong in first digit state
      4'b1000, 4'b0100, 4'b0010, 4'b0100, 4'b0010, 4'b0100,  // R4 wrong in second
      4'b1000, 4'b0100, 4'b0010, 4'b0010, 4'b0010, 4'b0100,  // R4 wrong in last
      4'b1000, 4'b0100, 4'b0010, 4'b0010, 4'b0101,           // R3 again
      4'b1000, 4'b0100, 4'b0010, 4'b0010, 4'b0101,           // R5 open -> idle
      4'b1010, 4'b0100, 4'b0010, 4'b0010, 4'b0101,           // R5 restart beats one
      4'b1100, 4'b0100, 4'b0010, 4'b0010, 4'b0101,           // R5 restart beats zero
      4'b1000, 4'b0110, 4'b0010, 4'b0010, 4'b0100            // R9 both digits -> fault
   };

   task automatic check_out(input string tag, input logic exp);
      n_checks++;
      if (unlock_c !== exp) begin
         n_fails++;
         $display("FAIL %s decode form: unlock=%b expected %b", tag, unlock_c, exp);
      end
      n_checks++;
      if (unlock_t !== exp) begin
         n_fails++;
         $display("FAIL %s table form (R10): unlock=%b expected %b", tag, unlock_t, exp);
      end
   endtask

   task automatic press(input logic [2:0] b, input int hold);
      @(negedge clk);
      {b_start, b_zero, b_one} = b;
      repeat (hold) @(posedge clk);
      @(negedge clk);
      {b_start, b_zero, b_one} = 3'b000;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_fails++;
         $display("FAIL R2 watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check_out("R1 after reset", 1'b0);

      // Table walk covering R3 R4 R5 R6 R7 R9
      for (int i = 0; i < NV; i++) begin
         press(VEC[i][3:1], 4);
         n_checks++;
         if (unlock_c !== VEC[i][0] || unlock_t !== VEC[i][0]) begin
            n_fails++;
            $display("FAIL R3/R4/R5/R6/R7/R9 step %0d: unlock=%b/%b expected %b",
                     i, unlock_c, unlock_t, VEC[i][0]);
         end
      end

      // R2: event timing, state changes at the third edge after the press
      press(3'b100, 4);
      press(3'b010, 4);
      press(3'b001, 4);
      press(3'b001, 4);
      @(negedge clk);
      b_zero = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_out("R2 no change two edges after press", 1'b0);
      @(posedge clk);
      @(negedge clk);
      check_out("R2 open at third edge", 1'b1);
      // R2: long hold of the zero button, no repeated event
      repeat (30) @(posedge clk);
      @(negedge clk);
      check_out("R2 held zero does not repeat", 1'b1);
      b_zero = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);

      // R8: idle cycles keep the open state
      repeat (50) @(posedge clk);
      @(negedge clk);
      check_out("R8 open held with no press", 1'b1);

      // R2: a long zero press counts once, so the sequence still opens
      press(3'b100, 4);
      press(3'b010, 25);
      press(3'b001, 4);
      press(3'b001, 4);
      press(3'b010, 4);
      check_out("R2 long press counted once", 1'b1);

      // R1: reset from open returns to idle
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check_out("R1 reset from open", 1'b0);
      press(3'b010, 4);
      press(3'b001, 4);
      press(3'b001, 4);
      press(3'b010, 4);
      check_out("R1 reset leaves idle, path opens", 1'b1);

      // R8: idle cycles in a middle state keep progress
      press(3'b100, 4);
      press(3'b010, 4);
      repeat (40) @(posedge clk);
      press(3'b001, 4);
      repeat (40) @(posedge clk);
      press(3'b001, 4);
      press(3'b010, 4);
      check_out("R8 progress kept across idle gaps", 1'b1);

      finish_run();
   end

endmodule